// File: doc/BRIEF.md
# Switchable-Layout Bank Mapper with Scanline Interrupt

This block turns processor writes into page numbers for a cartridge-style memory map. It keeps a control register, eight bank data registers and a mirroring register. From these it builds four 8 KB program page numbers and eight 1 KB pattern page numbers. Two control bits rearrange the slots: one exchanges the first and third program slots, and one exchanges the lower and upper halves of the pattern slots. Every page number is formed as an outer base ORed with the inner value after masking. The bases and masks come from a surrounding outer-bank block.

The block also holds a scanline interrupt counter. A single-cycle pulse marks each filtered rising edge of the video address line A12. On each pulse the counter reloads or counts down. When it reaches zero while interrupts are enabled, it raises a held interrupt request. A mode input hands the register space and the interrupt to a different personality. While that input is high, this block ignores both register writes and edge pulses.

Top module: `bank_irq_mapper`

## Requirements
- R1: A write is decoded only when `wr_en` is high, `alt_mode` is low and `wr_addr[15]` is 1. It is decoded on `wr_addr[14:13]` and `wr_addr[0]`: 00/0 loads control, 00/1 loads data register number control[2:0], 01/0 loads mirroring, 01/1 does nothing, 10/0 loads the interrupt latch, 10/1 requests a reload, 11/0 disables the interrupt and drops a pending request, 11/1 enables the interrupt. The register written is visible on the outputs from the clock edge that takes the write.
- R2: Program slot 1 shows data register 7 and slot 3 shows the all-ones page. With control bit 6 clear, slot 0 shows register 6 and slot 2 shows the all-ones page minus one. With control bit 6 set, slots 0 and 2 swap those two sources. Each program output equals `prg_base | (value & prg_mask)`.
- R3: Logical pattern slots 0 and 1 show register 0 with bit 0 forced to 0 and to 1. Slots 2 and 3 do the same for register 1. Slots 4 to 7 show registers 2 to 5. Control bit 7 XORs the physical slot index with 4. Each pattern output equals `chr_base | (value & chr_mask)`.
- R4: `mirror_horiz` equals bit 0 of the last mirroring write (1 = horizontal, 0 = vertical).
- R5: Each `a12_rise` pulse acts on the counter. If the counter is zero or a reload is pending, it loads the latch. Otherwise it decrements. The pending reload is then cleared, unless a reload request is written in the same cycle.
- R6: If the counter is zero after a pulse and the interrupt was enabled, `irq` goes high at that clock edge. It stays high until a disable write or reset. An enable write does not clear it.
- R7: While `alt_mode` is high, `a12_rise` pulses leave the counter unchanged and raise no interrupt, and all register writes are ignored.
- R8: After reset, data registers 0 to 7 hold 0, 2, 4, 5, 6, 7, 0xFC and 0xFD. Control and mirroring read 0. The interrupt is disabled and low, and the counter, latch and pending reload are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| alt_mode | input | 1 | High hands registers and interrupt to the other personality |
| a12_rise | input | 1 | Single-cycle pulse per filtered A12 rising edge |
| prg_base | input | PRG_W | Outer program base ORed into every program page |
| prg_mask | input | PRG_W | Mask applied to inner program values |
| chr_base | input | CHR_W | Outer pattern base ORed into every pattern page |
| chr_mask | input | CHR_W | Mask applied to inner pattern values |
| prg_page | output | 4 x PRG_W | Program page number per 8 KB slot |
| chr_page | output | 8 x CHR_W | Pattern page number per 1 KB slot |
| mirror_horiz | output | 1 | 1 = horizontal mirroring |
| irq | output | 1 | Held interrupt request, active high |

## Verification
Directed writes first set each layout bit on its own, so a swapped program slot can be told apart from a swapped pattern half and from a wrong register index. Narrow masks and non-zero bases then show whether the OR and the AND are applied in the right order. A countdown from a latch of 3 checks the exact pulse on which the interrupt fires. It also checks that a zero counter reloads instead of firing again, and that pulses sent in the alternate mode are really dropped, since counting them would make the interrupt fire early. A long pseudo-random run then mixes every decoded address, pulse timing, mode changes and mask changes, including writes that land in the same cycle as a pulse. It compares all outputs against a behavioural model on every clock.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int DATA_W = 8;
  localparam int NREG   = 8;
  localparam int SEL_W  = $clog2(NREG);

  // Decode key: {wr_addr[14:13], wr_addr[0]} within the upper half
  localparam logic [2:0] K_CTRL   = 3'b000;
  localparam logic [2:0] K_DATA   = 3'b001;
  localparam logic [2:0] K_MIRROR = 3'b010;
  localparam logic [2:0] K_LATCH  = 3'b100;
  localparam logic [2:0] K_RELOAD = 3'b101;
  localparam logic [2:0] K_OFF    = 3'b110;
  localparam logic [2:0] K_ON     = 3'b111;

  typedef struct packed {
    logic latch_we;
    logic reload_req;
    logic irq_off;
    logic irq_on;
  } irq_cmd_t;

  // Reset contents of bank data registers
  function automatic logic [DATA_W-1:0] bank_reset_val(input int idx);
    logic [DATA_W-1:0] ones;
    ones = '1;
    if (idx < 2)      return DATA_W'(idx * 2);
    else if (idx < 6) return DATA_W'(idx + 2);
    else              return ones - DATA_W'(9 - idx);
  endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [2:0]                  addr_top,
  input  logic                        addr_lsb,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        alt_mode,
  output logic                        prg_swap,
  output logic                        chr_swap,
  output logic [NREG-1:0][DATA_W-1:0] bank_q,
  output logic                        mirror_q,
  output irq_cmd_t                    cmd
);

  logic             hit;
  logic             ctrl_we, data_we, mir_we;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             prg_swap_q, prg_swap_d, chr_swap_q, chr_swap_d;
  logic             mirror_d;

  assign hit = wr_en & ~alt_mode & addr_top[2];

  always_comb begin
    cmd     = '0;
    ctrl_we = 1'b0;
    data_we = 1'b0;
    mir_we  = 1'b0;
    if (hit) begin
      case ({addr_top[1:0], addr_lsb})
        K_CTRL:   ctrl_we = 1'b1;
        K_DATA:   data_we = 1'b1;
        K_MIRROR: mir_we  = 1'b1;
        K_LATCH:  cmd.latch_we   = 1'b1;
        K_RELOAD: cmd.reload_req = 1'b1;
        K_OFF:    cmd.irq_off    = 1'b1;
        K_ON:     cmd.irq_on     = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    sel_d      = wr_data[SEL_W-1:0];
    prg_swap_d = wr_data[6];
    chr_swap_d = wr_data[7];
    mirror_d   = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      prg_swap_q <= 1'b0;
      chr_swap_q <= 1'b0;
      mirror_q   <= 1'b0;
    end else begin
      if (ctrl_we) begin
        sel_q      <= sel_d;
        prg_swap_q <= prg_swap_d;
        chr_swap_q <= chr_swap_d;
      end
      if (mir_we) mirror_q <= mirror_d;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    logic bank_ce;
    assign bank_ce = data_we && (sel_q == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q[g] <= bank_reset_val(g);
      else if (bank_ce) bank_q[g] <= wr_data;
    end
  end

  assign prg_swap = prg_swap_q;
  assign chr_swap = chr_swap_q;

endmodule

// File: rtl/mapper_bank_map.sv
module mapper_bank_map
  import mapper_pkg::*;
#(
  parameter int PW = 9,
  parameter int CW = 13
) (
  input  logic                        prg_swap,
  input  logic                        chr_swap,
  input  logic [NREG-1:0][DATA_W-1:0] bank_q,
  input  logic [PW-1:0]               prg_base,
  input  logic [PW-1:0]               prg_mask,
  input  logic [CW-1:0]               chr_base,
  input  logic [CW-1:0]               chr_mask,
  output logic [3:0][PW-1:0]          prg_page,
  output logic [7:0][CW-1:0]          chr_page
);

  localparam logic [PW-1:0] LAST_PG   = '1;
  localparam logic [PW-1:0] SECOND_PG = LAST_PG - 1'b1;

  logic [3:0][PW-1:0] prg_raw;
  logic [7:0][CW-1:0] chr_raw;

  always_comb begin
    prg_raw[0] = prg_swap ? SECOND_PG : PW'(bank_q[6]);
    prg_raw[1] = PW'(bank_q[7]);
    prg_raw[2] = prg_swap ? PW'(bank_q[6]) : SECOND_PG;
    prg_raw[3] = LAST_PG;
  end

  for (genvar s = 0; s < 4; s++) begin : g_prg
    assign prg_page[s] = prg_base | (prg_raw[s] & prg_mask);
  end

  always_comb begin
    chr_raw[0] = CW'(bank_q[0] & ~DATA_W'(1));
    chr_raw[1] = CW'(bank_q[0] |  DATA_W'(1));
    chr_raw[2] = CW'(bank_q[1] & ~DATA_W'(1));
    chr_raw[3] = CW'(bank_q[1] |  DATA_W'(1));
    for (int k = 4; k < 8; k++) chr_raw[k] = CW'(bank_q[k-2]);
  end

  for (genvar s = 0; s < 8; s++) begin : g_chr
    logic [2:0] src;
    assign src         = 3'(s) ^ {chr_swap, 2'b00};
    assign chr_page[s] = chr_base | (chr_raw[src] & chr_mask);
  end

endmodule

// File: rtl/mapper_irq.sv
module mapper_irq
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  irq_cmd_t          cmd,
  input  logic [DATA_W-1:0] wr_val,
  output logic              irq
);

  logic [DATA_W-1:0] latch_q, latch_d, cnt_q, cnt_d;
  logic              flag_q, flag_d, en_q, en_d, irq_q, irq_d;
  logic              flag_ce, en_ce;

  always_comb begin
    latch_d = wr_val;
    if ((cnt_q == '0) || flag_q) cnt_d = latch_q;
    else                         cnt_d = cnt_q - 1'b1;
    flag_ce = rise | cmd.reload_req;
    flag_d  = cmd.reload_req;
    en_ce   = cmd.irq_on | cmd.irq_off;
    en_d    = ~cmd.irq_off;
    if (cmd.irq_off) irq_d = 1'b0;
    else             irq_d = irq_q | (rise & en_q & (cnt_d == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (cmd.latch_we) latch_q <= latch_d;
      if (rise)         cnt_q   <= cnt_d;
      if (flag_ce)      flag_q  <= flag_d;
      if (en_ce)        en_q    <= en_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/bank_irq_mapper.sv
module bank_irq_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_W = 9,
  parameter int CHR_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [15:0]             wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    alt_mode,
  input  logic                    a12_rise,
  input  logic [PRG_W-1:0]        prg_base,
  input  logic [PRG_W-1:0]        prg_mask,
  input  logic [CHR_W-1:0]        chr_base,
  input  logic [CHR_W-1:0]        chr_mask,
  output logic [3:0][PRG_W-1:0]   prg_page,
  output logic [7:0][CHR_W-1:0]   chr_page,
  output logic                    mirror_horiz,
  output logic                    irq
);

  logic                        prg_swap, chr_swap, mirror_q;
  logic [NREG-1:0][DATA_W-1:0] bank_q;
  irq_cmd_t                    cmd;
  logic                        rise_gated;
  logic                        unused_addr_bits;

  assign unused_addr_bits = ^wr_addr[12:1];
  assign rise_gated       = a12_rise & ~alt_mode;

  mapper_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr_top (wr_addr[15:13]),
    .addr_lsb (wr_addr[0]),
    .wr_data  (wr_data),
    .alt_mode (alt_mode),
    .prg_swap (prg_swap),
    .chr_swap (chr_swap),
    .bank_q   (bank_q),
    .mirror_q (mirror_q),
    .cmd      (cmd)
  );

  mapper_bank_map #(.PW(PRG_W), .CW(CHR_W)) u_map (
    .prg_swap (prg_swap),
    .chr_swap (chr_swap),
    .bank_q   (bank_q),
    .prg_base (prg_base),
    .prg_mask (prg_mask),
    .chr_base (chr_base),
    .chr_mask (chr_mask),
    .prg_page (prg_page),
    .chr_page (chr_page)
  );

  mapper_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise_gated),
    .cmd    (cmd),
    .wr_val (wr_data),
    .irq    (irq)
  );

  assign mirror_horiz = mirror_q;

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter int PW = 9,
  parameter int CW = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [2:0]           addr_top,
  input logic                 addr_lsb,
  input logic                 alt_mode,
  input logic                 irq,
  input logic                 mirror_horiz,
  input logic [3:0][PW-1:0]   prg_page,
  input logic [PW-1:0]        prg_base,
  input logic [PW-1:0]        prg_mask,
  input logic [7:0][CW-1:0]   chr_page,
  input logic                 chr_mask_lsb
);

  logic clr_wr, mir_wr;
  assign clr_wr = wr_en && !alt_mode && addr_top == 3'b111 && !addr_lsb;
  assign mir_wr = wr_en && !alt_mode && addr_top == 3'b101 && !addr_lsb;

  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  a_r6_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !irq);

  a_r7_alt_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode && !irq) |=> !irq);

  a_r4_mirror_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mir_wr |=> $stable(mirror_horiz));

  a_r2_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
    prg_page[3] == (prg_base | prg_mask));

  a_r3_pair_odd: assert property (@(posedge clk) disable iff (!rst_n)
    chr_mask_lsb |-> ((chr_page[1] == (chr_page[0] | CW'(1))) ||
                      (chr_page[5] == (chr_page[4] | CW'(1)))));

endmodule

bind bank_irq_mapper mapper_checker #(.PW(PRG_W), .CW(CHR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .addr_top     (wr_addr[15:13]),
  .addr_lsb     (wr_addr[0]),
  .alt_mode     (alt_mode),
  .irq          (irq),
  .mirror_horiz (mirror_horiz),
  .prg_page     (prg_page),
  .prg_base     (prg_base),
  .prg_mask     (prg_mask),
  .chr_page     (chr_page),
  .chr_mask_lsb (chr_mask[0])
);

// File: tb/bank_irq_mapper_tb.sv
module bank_irq_mapper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 9;
  localparam int CW = 13;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [15:0]        wr_addr = '0;
  logic [7:0]         wr_data = '0;
  logic               alt_mode = 1'b0;
  logic               a12_rise = 1'b0;
  logic [PW-1:0]      prg_base = '0;
  logic [PW-1:0]      prg_mask = '1;
  logic [CW-1:0]      chr_base = '0;
  logic [CW-1:0]      chr_mask = '1;
  logic [3:0][PW-1:0] prg_page;
  logic [7:0][CW-1:0] chr_page;
  logic               mirror_horiz;
  logic               irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_irq_mapper #(.PRG_W(PW), .CHR_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alt_mode(alt_mode), .a12_rise(a12_rise), .prg_base(prg_base), .prg_mask(prg_mask),
    .chr_base(chr_base), .chr_mask(chr_mask), .prg_page(prg_page), .chr_page(chr_page),
    .mirror_horiz(mirror_horiz), .irq(irq)
  );

  // Behavioural reference model
  logic [7:0] m_reg [8];
  logic [7:0] m_ctrl, m_latch, m_cnt;
  logic       m_mir, m_flag, m_en, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 8'd0; m_reg[1] = 8'd2; m_reg[2] = 8'd4; m_reg[3] = 8'd5;
      m_reg[4] = 8'd6; m_reg[5] = 8'd7; m_reg[6] = 8'hFC; m_reg[7] = 8'hFD;
      m_ctrl = 0; m_latch = 0; m_cnt = 0; m_mir = 0; m_flag = 0; m_en = 0; m_irq = 0;
    end else begin
      bit old_en;
      old_en = m_en;
      if (a12_rise && !alt_mode) begin
        if (m_cnt == 0 || m_flag) m_cnt = m_latch;
        else m_cnt = m_cnt - 1;
        m_flag = 0;
        if (m_cnt == 0 && old_en) m_irq = 1;
      end
      if (wr_en && !alt_mode && wr_addr[15]) begin
        case ({wr_addr[14:13], wr_addr[0]})
          3'b000: m_ctrl = wr_data;
          3'b001: m_reg[m_ctrl[2:0]] = wr_data;
          3'b010: m_mir = wr_data[0];
          3'b100: m_latch = wr_data;
          3'b101: m_flag = 1;
          3'b110: begin m_en = 0; m_irq = 0; end
          3'b111: m_en = 1;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_prg(int slot);
    int v;
    case (slot)
      0: v = m_ctrl[6] ? 'h1FE : m_reg[6];
      1: v = m_reg[7];
      2: v = m_ctrl[6] ? m_reg[6] : 'h1FE;
      default: v = 'h1FF;
    endcase
    return (int'(prg_base) | (v & int'(prg_mask))) & 'h1FF;
  endfunction

  function automatic int exp_chr(int slot);
    int k, v;
    k = m_ctrl[7] ? (slot ^ 4) : slot;
    case (k)
      0: v = m_reg[0] & 'hFE;
      1: v = m_reg[0] | 1;
      2: v = m_reg[1] & 'hFE;
      3: v = m_reg[1] | 1;
      default: v = m_reg[k-2];
    endcase
    return (int'(chr_base) | (v & int'(chr_mask))) & 'h1FFF;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Per-clock comparison with the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int s = 0; s < 4; s++) check("R2 prg slot", int'(prg_page[s]), exp_prg(s));
      for (int s = 0; s < 8; s++) check("R3 chr slot", int'(chr_page[s]), exp_chr(s));
      check("R4 mirroring", int'(mirror_horiz), int'(m_mir));
      check("R6 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); a12_rise = 1;
    @(negedge clk); a12_rise = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset contents
    check("R8 prg0", int'(prg_page[0]), 'h0FC);
    check("R8 prg1", int'(prg_page[1]), 'h0FD);
    check("R8 prg2", int'(prg_page[2]), 'h1FE);
    check("R8 prg3", int'(prg_page[3]), 'h1FF);
    for (int s = 0; s < 4; s++) check("R8 chr low", int'(chr_page[s]), s);
    for (int s = 4; s < 8; s++) check("R8 chr high", int'(chr_page[s]), s);
    check("R8 irq", int'(irq), 0);
    check("R8 mirror", int'(mirror_horiz), 0);

    // R1 R2 layout swap with register 6
    wr(16'h8000, 8'h46); wr(16'h8001, 8'h12);
    check("R1 R2 prg2 reg6", int'(prg_page[2]), 'h012);
    check("R2 prg0 second-last", int'(prg_page[0]), 'h1FE);
    // R3 pattern halves swapped
    wr(16'h8000, 8'h82); wr(16'h8001, 8'h33);
    check("R3 swapped slot0", int'(chr_page[0]), 'h033);
    check("R3 swapped slot4", int'(chr_page[4]), 'h000);
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h21);
    check("R3 even page", int'(chr_page[0]), 'h020);
    check("R3 odd page", int'(chr_page[1]), 'h021);
    // R4 mirroring and R1 ignored addresses
    wr(16'hA000, 8'h01);
    check("R4 horizontal", int'(mirror_horiz), 1);
    wr(16'hA001, 8'h00);
    check("R1 A001 no effect", int'(mirror_horiz), 1);
    wr(16'h0001, 8'h55);
    check("R1 low address ignored", int'(chr_page[0]), 'h020);
    // R2 R3 base and mask
    @(negedge clk); prg_base = 'h100; prg_mask = 'h00F; chr_base = 'h1000; chr_mask = 'h0F0;
    @(negedge clk);
    check("R2 masked slot1", int'(prg_page[1]), 'h10D);
    check("R2 masked slot3", int'(prg_page[3]), 'h10F);
    check("R3 masked slot1", int'(chr_page[1]), 'h1020);
    prg_base = '0; prg_mask = '1; chr_base = '0; chr_mask = '1;

    // R5 R6 countdown from 3
    wr(16'hC000, 8'd3); wr(16'hC001, 8'd0); wr(16'hE001, 8'd0);
    for (int i = 0; i < 3; i++) begin pulse(); check("R5 no irq before zero", int'(irq), 0); end
    pulse(); check("R6 irq at zero", int'(irq), 1);
    repeat (3) @(negedge clk);
    check("R6 irq held", int'(irq), 1);
    wr(16'hE001, 8'd0); check("R6 enable keeps irq", int'(irq), 1);
    wr(16'hE000, 8'd0); check("R6 disable clears", int'(irq), 0);
    wr(16'hE001, 8'd0);
    pulse(); check("R5 zero reloads", int'(irq), 0);
    pulse(); pulse(); check("R5 counting", int'(irq), 0);
    pulse(); check("R5 R6 fires again", int'(irq), 1);
    wr(16'hE000, 8'd0); wr(16'hE001, 8'd0);

    // R7 alternate mode
    @(negedge clk); alt_mode = 1;
    repeat (4) pulse();
    check("R7 pulses ignored", int'(irq), 0);
    wr(16'hA000, 8'h00);
    check("R7 write ignored", int'(mirror_horiz), 1);
    @(negedge clk); alt_mode = 0;
    pulse(); check("R7 counter kept at zero reloads", int'(irq), 0);
    pulse(); pulse(); pulse();
    check("R7 count resumes", int'(irq), 1);
    wr(16'hE000, 8'd0);

    // Mixed pseudo-random traffic, compared per clock with the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      seed = seed * 32'd1103515245 + 32'd12345;
      wr_en    = seed[20];
      wr_addr  = {1'b1, seed[23:22], 12'h000, seed[24]};
      if (seed[30:29] == 2'b00) wr_addr[15] = 1'b0;
      wr_data  = (seed[23:22] == 2'b10) ? {5'd0, seed[11:9]} : seed[15:8];
      a12_rise = seed[26] & seed[25];
      if (seed[31:27] == 5'd3) alt_mode = ~alt_mode;
      if (seed[31:27] == 5'd7) begin
        prg_base = PW'(seed[8:0] & 9'h1C0); prg_mask = PW'(seed[5:0] | 6'h3);
        chr_base = CW'(seed[12:0] & 13'h1F00); chr_mask = CW'(seed[16:9]);
      end
    end
    @(negedge clk); wr_en = 0; a12_rise = 0; alt_mode = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule